// File: doc/BRIEF.md
# Effective Address and Immediate Generator

This unit sits beside the decoder of a 32-bit core whose instructions are 16 bits wide. On each issued operation it receives an addressing-mode selector, the raw 12-bit operand field, the program counter, one general register value and the base register value. It returns either a 32-bit effective address or a 32-bit extended immediate, one cycle later, with a valid flag.

Branch targets are formed from the PC with a signed displacement counted in 16-bit units, or from the PC plus a whole register. Data addresses are formed from a register, the base register or the PC, plus an unsigned displacement. That displacement is counted in operand-size units. Immediates are sign- or zero-extended, and in one case scaled, according to the operation class that uses them. A selector the unit does not recognise gives a zero result and raises an error flag.

Top module: `eag_top`

## Requirements
- R1: Mode 0 (short branch) gives pc + 2 × sign-extended field[7:0].
- R2: Mode 1 (long branch) gives pc + 2 × sign-extended field[11:0].
- R3: Mode 2 (register branch) gives pc + regVal, with no scaling.
- R4: Mode 3 (register plus small offset) gives regVal + zero-extended field[3:0] × scale. The scale is 1, 2 or 4 for opSize 0 (byte), 1 (word) or 2 (longword).
- R5: Mode 4 (base plus offset) gives baseVal + zero-extended field[7:0] × scale, with the scale taken from opSize as in R4.
- R6: Mode 5 (PC-relative data) gives pc + zero-extended field[7:0] × scale, with the scale taken from opSize as in R4.
- R7: Mode 6 (immediate for logic operations: test, AND, OR, XOR) gives zero-extended field[7:0]; field[11:8] has no effect.
- R8: Mode 7 (immediate for move, add, compare-equal) gives sign-extended field[7:0].
- R9: Mode 8 (trap number) gives zero-extended field[7:0] × 4, so result[1:0] is always 0.
- R10: Inputs with inVld high set outVld high at the next rising edge, and the result appears at that same edge. With inVld low, outVld is low at the next edge. A synchronous active-high rst clears outVld.
- R11: A mode from 9 to 15, or opSize 3 in modes 3 to 5, gives result 0 with err high in the same cycle as outVld. err is low on every other output.
- R12: Every sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inVld | input | 1 | Inputs are valid this cycle |
| mode | input | 4 | Addressing mode / operation class selector |
| opSize | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| field | input | 12 | Raw displacement or immediate field |
| pc | input | 32 | Current program counter |
| regVal | input | 32 | General register value |
| baseVal | input | 32 | Base register value |
| outVld | output | 1 | Result valid |
| result | output | 32 | Effective address or extended immediate |
| err | output | 1 | Unsupported selector flag |

## Verification
The error path and the normal path can both be active in one cycle. A rejected operation's zero result and error flag leave the output register at the same edge that samples the next, legal operation. The bench issues back-to-back streams in which illegal selectors sit between good ones, with no idle cycle. Its scoreboard then requires that err is set only on the rejected item, and that the item after it carries its full computed value with err clear.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int FIELD_W = 12;
  localparam int MODE_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    M_BRA8   = 4'd0,
    M_BRA12  = 4'd1,
    M_PCREG  = 4'd2,
    M_REGD4  = 4'd3,
    M_BASED8 = 4'd4,
    M_PCD8   = 4'd5,
    M_IMMLOG = 4'd6,
    M_IMMARI = 4'd7,
    M_IMMTRP = 4'd8
  } mode_e;

  typedef enum logic [1:0] {B_PC, B_REG, B_BASE, B_ZERO} baseSel_e;
  typedef enum logic [2:0] {O_SEXT8, O_SEXT12, O_ZEXT4, O_ZEXT8, O_REG} offSel_e;

  typedef struct packed {
    logic     load;
    logic     forceZero;
    baseSel_e baseSel;
    offSel_e  offSel;
    logic [1:0] shAmt;
  } strobe_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inVld,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        opSize,
  output strobe_t           st,
  output logic              outVld,
  output logic              err
);
  logic bad;

  always_comb begin
    st.load      = inVld;
    st.forceZero = 1'b0;
    st.baseSel   = B_ZERO;
    st.offSel    = O_ZEXT8;
    st.shAmt     = 2'd0;
    bad          = 1'b0;
    case (mode)
      M_BRA8:   begin st.baseSel = B_PC;   st.offSel = O_SEXT8;  st.shAmt = 2'd1; end
      M_BRA12:  begin st.baseSel = B_PC;   st.offSel = O_SEXT12; st.shAmt = 2'd1; end
      M_PCREG:  begin st.baseSel = B_PC;   st.offSel = O_REG; end
      M_REGD4:  begin st.baseSel = B_REG;  st.offSel = O_ZEXT4; st.shAmt = opSize; bad = (opSize == 2'd3); end
      M_BASED8: begin st.baseSel = B_BASE; st.offSel = O_ZEXT8; st.shAmt = opSize; bad = (opSize == 2'd3); end
      M_PCD8:   begin st.baseSel = B_PC;   st.offSel = O_ZEXT8; st.shAmt = opSize; bad = (opSize == 2'd3); end
      M_IMMLOG: begin st.offSel = O_ZEXT8; end
      M_IMMARI: begin st.offSel = O_SEXT8; end
      M_IMMTRP: begin st.offSel = O_ZEXT8; st.shAmt = 2'd2; end
      default:  bad = 1'b1;
    endcase
    if (bad) begin
      st.forceZero = 1'b1;
      st.shAmt     = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outVld <= 1'b0;
      err    <= 1'b0;
    end else begin
      outVld <= inVld;
      err    <= inVld & bad;
    end
  end

  // R10: issue produces a valid output at the next edge
  a_r10_issue: assert property (@(posedge clk) disable iff (rst) inVld |=> outVld);
  // R10: no issue, no output
  a_r10_idle: assert property (@(posedge clk) disable iff (rst) !inVld |=> !outVld);
  // R11: error flag only accompanies a valid output
  a_r11_err_with_vld: assert property (@(posedge clk) disable iff (rst) err |-> outVld);
endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            st,
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  pc,
  input  logic [DATA_W-1:0]  regVal,
  input  logic [DATA_W-1:0]  baseVal,
  output logic [DATA_W-1:0]  result
);
  logic [DATA_W-1:0] baseV, offV, sum;

  always_comb begin
    case (st.baseSel)
      B_PC:    baseV = pc;
      B_REG:   baseV = regVal;
      B_BASE:  baseV = baseVal;
      default: baseV = '0;
    endcase
    case (st.offSel)
      O_SEXT8:  offV = {{(DATA_W-8){field[7]}}, field[7:0]};
      O_SEXT12: offV = {{(DATA_W-12){field[11]}}, field[11:0]};
      O_ZEXT4:  offV = {{(DATA_W-4){1'b0}}, field[3:0]};
      O_ZEXT8:  offV = {{(DATA_W-8){1'b0}}, field[7:0]};
      default:  offV = regVal;
    endcase
    sum = baseV + (offV << st.shAmt);
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (st.load) result <= st.forceZero ? '0 : sum;
  end

  // R11: a rejected operation leaves a zero result
  a_r11_zero_result: assert property (@(posedge clk) disable iff (rst)
    (st.load && st.forceZero) |=> (result == '0));
  // R10: result holds while nothing is issued
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !st.load |=> $stable(result));
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inVld,
  input  logic [MODE_W-1:0]  mode,
  input  logic [1:0]         opSize,
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  pc,
  input  logic [DATA_W-1:0]  regVal,
  input  logic [DATA_W-1:0]  baseVal,
  output logic               outVld,
  output logic [DATA_W-1:0]  result,
  output logic               err
);
  strobe_t st;

  eag_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inVld(inVld), .mode(mode), .opSize(opSize),
    .st(st), .outVld(outVld), .err(err)
  );

  eag_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rst(rst), .st(st), .field(field), .pc(pc),
    .regVal(regVal), .baseVal(baseVal), .result(result)
  );

  // R9: trap vectors are always word aligned
  a_r9_trap_aligned: assert property (@(posedge clk) disable iff (rst)
    (inVld && mode == M_IMMTRP) |=> (result[1:0] == 2'b00 && !err));
endmodule

// File: tb/test_eag_top.sv
module test_eag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVld = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  opSize = '0;
  logic [11:0] field = '0;
  logic [31:0] pc = '0, regVal = '0, baseVal = '0;
  logic        outVld, err;
  logic [31:0] result;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] res; logic err; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst(rst), .inVld(inVld), .mode(mode), .opSize(opSize),
    .field(field), .pc(pc), .regVal(regVal), .baseVal(baseVal),
    .outVld(outVld), .result(result), .err(err)
  );

  function automatic logic [32:0] model(logic [3:0] m, logic [1:0] sz, logic [11:0] f,
                                        logic [31:0] p, logic [31:0] r, logic [31:0] b);
    logic [31:0] s8, s12, z8, z4, sc;
    s8  = f[7]  ? {24'hFFFFFF, f[7:0]} : {24'h0, f[7:0]};
    s12 = f[11] ? {20'hFFFFF, f[11:0]} : {20'h0, f[11:0]};
    z8  = {24'h0, f[7:0]};
    z4  = {28'h0, f[3:0]};
    sc  = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    if (sz == 2'd3 && (m == 4'd3 || m == 4'd4 || m == 4'd5)) return {1'b1, 32'h0};
    case (m)
      4'd0: return {1'b0, p + s8 * 32'd2};
      4'd1: return {1'b0, p + s12 * 32'd2};
      4'd2: return {1'b0, p + r};
      4'd3: return {1'b0, r + z4 * sc};
      4'd4: return {1'b0, b + z8 * sc};
      4'd5: return {1'b0, p + z8 * sc};
      4'd6: return {1'b0, z8};
      4'd7: return {1'b0, s8};
      4'd8: return {1'b0, z8 * 32'd4};
      default: return {1'b1, 32'h0};
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got err=%0b res=%h, want err=%0b res=%h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic send(logic [3:0] m, logic [1:0] sz, logic [11:0] f,
                      logic [31:0] p, logic [31:0] r, logic [31:0] b, string tag);
    logic [32:0] e;
    item_t it;
    @(negedge clk);
    inVld = 1'b1; mode = m; opSize = sz; field = f; pc = p; regVal = r; baseVal = b;
    e = model(m, sz, f, p, r, b);
    it.res = e[31:0]; it.err = e[32]; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inVld = 1'b0;
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && outVld) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected outVld", {err, result}, 33'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(result === it.res && err === it.err, it.tag, {err, result}, {it.err, it.res});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 33'h0, 33'h0);
    finishUp();
  end

  initial begin
    inVld = 1'b1;
    repeat (3) @(negedge clk);
    check(outVld === 1'b0, "R10 reset clears outVld", {32'h0, outVld}, 33'h0);
    @(negedge clk);
    rst = 1'b0; inVld = 1'b0;
    @(negedge clk);
    check(outVld === 1'b0, "R10 idle after reset", {32'h0, outVld}, 33'h0);

    send(4'd0, 2'd0, 12'h0FE, 32'h0000_1000, 32'h0, 32'h0, "R1 short branch back");
    send(4'd0, 2'd0, 12'hF7F, 32'h0000_1000, 32'h0, 32'h0, "R1 short branch fwd");
    send(4'd1, 2'd0, 12'h800, 32'h0000_4000, 32'h0, 32'h0, "R2 long branch min");
    send(4'd1, 2'd0, 12'h7FF, 32'h0000_4000, 32'h0, 32'h0, "R2 long branch max");
    send(4'd2, 2'd2, 12'hFFF, 32'h0000_0100, 32'hFFFF_FFF0, 32'h0, "R3 R12 pc+reg wrap");
    send(4'd3, 2'd0, 12'hFFF, 32'h0, 32'h2000_0000, 32'h0, "R4 reg+disp byte");
    send(4'd3, 2'd1, 12'h00F, 32'h0, 32'h2000_0000, 32'h0, "R4 reg+disp word");
    send(4'd3, 2'd2, 12'h00F, 32'h0, 32'h2000_0000, 32'h0, "R4 reg+disp long");
    send(4'd9, 2'd0, 12'h123, 32'h5, 32'h6, 32'h7, "R11 bad mode 9");
    send(4'd4, 2'd2, 12'h0FF, 32'h0, 32'h0, 32'h8000_0000, "R5 base+disp long");
    send(4'd4, 2'd1, 12'h080, 32'h0, 32'h0, 32'hFFFF_FF00, "R5 R12 base wrap");
    send(4'd3, 2'd3, 12'h00F, 32'h0, 32'h1000, 32'h0, "R11 size 3 scaled");
    send(4'd5, 2'd1, 12'h080, 32'h0000_3000, 32'h0, 32'h0, "R6 pc data word");
    send(4'd5, 2'd0, 12'hFFF, 32'h0000_3000, 32'h0, 32'h0, "R6 pc data byte");
    send(4'd6, 2'd0, 12'hA80, 32'h0, 32'h0, 32'h0, "R7 logic imm zext");
    send(4'd6, 2'd2, 12'h0FF, 32'h0, 32'h0, 32'h0, "R7 logic imm ff");
    send(4'd7, 2'd0, 12'h080, 32'h0, 32'h0, 32'h0, "R8 arith imm neg");
    send(4'd7, 2'd0, 12'h07F, 32'h0, 32'h0, 32'h0, "R8 arith imm pos");
    send(4'd8, 2'd0, 12'h0FF, 32'h0, 32'h0, 32'h0, "R9 trap max");
    send(4'd15, 2'd1, 12'hFFF, 32'h1, 32'h1, 32'h1, "R11 bad mode 15");
    send(4'd8, 2'd0, 12'h021, 32'h0, 32'h0, 32'h0, "R9 R11 trap after error");
    send(4'd0, 2'd0, 12'h002, 32'hFFFF_FFFE, 32'h0, 32'h0, "R12 branch wraps");
    idle(1);
    @(negedge clk);
    check(outVld === 1'b0, "R10 outVld low when idle", {32'h0, outVld}, 33'h0);
    idle(2);
    send(4'd2, 2'd0, 12'h0, 32'h0000_0010, 32'h0000_0020, 32'h0, "R3 pc+reg after gap");
    idle(3);
    check(q.size() == 0, "R10 all items returned", {1'b0, 32'(q.size())}, 33'h0);
    finishUp();
  end
endmodule